// File: doc/BRIEF.md
# Dual-Issue Instruction Dispatch Controller

The controller looks at the two oldest entries of an instruction queue every cycle and decides whether none, the older one, or both of them may leave for execution. Each entry carries a valid bit, the identifier of the execution unit it needs, and a flag telling whether it produces a result and so needs a destination rename register. Against these it weighs three resources: a per-unit busy vector, a count of free rename registers and a count of free completion-queue entries.

Dispatch is strictly in program order. The younger entry may go only when the older entry goes in the same cycle, targets a different unit, and the pooled supply covers both entries. The controller has no storage. Its grants, its dispatched count and its allocation requests follow the inputs within the same cycle, so the queue can shift and the resource pools can allocate on the next clock edge.

Top module: `dispatch_ctrl`

## Requirements
- R1: At most two entries dispatch in a cycle. `grant[1]` (younger entry) is never set unless `grant[0]` (older entry) is set, and `disp_count` equals the number of set grant bits (0, 1 or 2).
- R2: An entry dispatches only when it is valid and `unit_busy[unit]` is 0 for its target unit.
- R3: An entry whose result flag is set dispatches only when a rename register is available for it. `ren_alloc` never exceeds `ren_free`.
- R4: Every dispatched entry takes one completion-queue entry. With `cq_free` equal to 0 nothing dispatches, and `cq_alloc` never exceeds `cq_free`.
- R5: When both entries name the same unit, the younger entry is held and at most the older one dispatches.
- R6: A two-entry dispatch needs `cq_free` of at least 2 and `ren_free` of at least the number of result-writing entries in the pair. When the older entry can go but the pair cannot, only the older entry dispatches.
- R7: An invalid entry never dispatches and adds nothing to `ren_alloc` or `cq_alloc`. An invalid older entry blocks the younger one.
- R8: `ren_alloc` equals the number of dispatched entries with the result flag set, and `cq_alloc` equals `disp_count`.
- R9: All outputs are combinational in the inputs and take the new value in the same cycle as an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slot0_valid | input | 1 | Older queue entry holds an instruction |
| slot0_unit | input | UNIT_W | Execution unit targeted by the older entry |
| slot0_wr | input | 1 | Older entry writes a result and needs a rename register |
| slot1_valid | input | 1 | Younger queue entry holds an instruction |
| slot1_unit | input | UNIT_W | Execution unit targeted by the younger entry |
| slot1_wr | input | 1 | Younger entry writes a result and needs a rename register |
| unit_busy | input | NUM_UNITS | Bit u set: unit u has no vacancy |
| ren_free | input | REN_W | Free rename registers |
| cq_free | input | CQ_W | Free completion-queue entries |
| grant | output | 2 | Bit 0 older entry dispatches, bit 1 younger entry dispatches |
| disp_count | output | 2 | Number of entries dispatched, used as the queue shift amount |
| ren_alloc | output | 2 | Rename registers to allocate this cycle |
| cq_alloc | output | 2 | Completion-queue entries to allocate this cycle |

## Verification
A vector table covers one or two valid entries on distinct free units, a busy older unit against a busy younger unit, a shared target unit, and supplies that are either exhausted or cover only the older entry. Together these show which of the three resource gates stopped a pair. Directed cases cover an all-invalid queue, an invalid older entry in front of a valid younger one, and a valid older entry with an invalid younger entry whose result flag is set. The last case shows that invalid entries take no resources. A sweep over small completion-queue and rename counts, every combination of result flags, and shared or distinct units is compared with a separate model in the bench. It finds the exact thresholds where one dispatch becomes two.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  // Supply check on a common wide scale so any counter width compares cleanly.
  function automatic logic supply_covers(input logic [15:0] avail, input logic [15:0] need);
    return avail >= need;
  endfunction

  // Number of set bits in a two-entry flag pair.
  function automatic logic [1:0] pair_pop(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction

endpackage

// File: rtl/dispatch_slot_probe.sv
module dispatch_slot_probe #(
  parameter int NUM_UNITS = 8,
  parameter int UNIT_W    = $clog2(NUM_UNITS)
) (
  input  logic                 valid,
  input  logic [UNIT_W-1:0]    unit,
  input  logic [NUM_UNITS-1:0] unit_busy,
  output logic                 unit_ready
);
  localparam logic [UNIT_W:0] UNIT_LIMIT = NUM_UNITS[UNIT_W:0];

  logic in_range;
  logic vacancy;

  always_comb begin
    in_range   = {1'b0, unit} < UNIT_LIMIT;
    vacancy    = in_range && !unit_busy[unit];
    unit_ready = valid && vacancy;
  end

  always_comb begin
    AST_READY_NEEDS_VACANCY: assert (!(unit_ready && unit_busy[unit])) // R2
      else $error("ready entry targets busy unit");
    AST_READY_NEEDS_VALID: assert (valid || !unit_ready) // R7
      else $error("invalid entry marked ready");
  end

endmodule

// File: rtl/dispatch_supply_gate.sv
module dispatch_supply_gate
  import dispatch_pkg::*;
#(
  parameter int REN_W = 6,
  parameter int CQ_W  = 4
) (
  input  logic             wr0,
  input  logic             wr1,
  input  logic [REN_W-1:0] ren_free,
  input  logic [CQ_W-1:0]  cq_free,
  output logic             solo_fits,
  output logic             pair_fits
);
  logic [1:0] pair_ren_need;

  always_comb begin
    pair_ren_need = pair_pop(wr0, wr1);
    solo_fits = supply_covers(16'(cq_free), 16'd1) &&
                supply_covers(16'(ren_free), 16'(wr0));
    pair_fits = supply_covers(16'(cq_free), 16'd2) &&
                supply_covers(16'(ren_free), 16'(pair_ren_need));
  end

  always_comb begin
    AST_PAIR_IMPLIES_SOLO: assert (!pair_fits || solo_fits) // R6
      else $error("pair fits but single entry does not");
    AST_EMPTY_CQ_BLOCKS: assert (cq_free != '0 || !solo_fits) // R4
      else $error("supply passes with empty completion queue");
  end

endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int UNIT_W    = $clog2(NUM_UNITS),
  parameter int REN_W     = 6,
  parameter int CQ_W      = 4
) (
  input  logic                 slot0_valid,
  input  logic [UNIT_W-1:0]    slot0_unit,
  input  logic                 slot0_wr,
  input  logic                 slot1_valid,
  input  logic [UNIT_W-1:0]    slot1_unit,
  input  logic                 slot1_wr,
  input  logic [NUM_UNITS-1:0] unit_busy,
  input  logic [REN_W-1:0]     ren_free,
  input  logic [CQ_W-1:0]      cq_free,
  output logic [1:0]           grant,
  output logic [1:0]           disp_count,
  output logic [1:0]           ren_alloc,
  output logic [1:0]           cq_alloc
);
  localparam int SLOTS = 2;

  logic [SLOTS-1:0] slot_valid;
  logic [UNIT_W-1:0] slot_unit [SLOTS];
  logic [SLOTS-1:0] unit_ready;
  logic solo_fits, pair_fits;
  logic unit_clash;

  assign slot_valid   = {slot1_valid, slot0_valid};
  assign slot_unit[0] = slot0_unit;
  assign slot_unit[1] = slot1_unit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_probe
    dispatch_slot_probe #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_probe (
      .valid     (slot_valid[s]),
      .unit      (slot_unit[s]),
      .unit_busy (unit_busy),
      .unit_ready(unit_ready[s])
    );
  end

  dispatch_supply_gate #(.REN_W(REN_W), .CQ_W(CQ_W)) u_supply (
    .wr0      (slot0_wr),
    .wr1      (slot1_wr),
    .ren_free (ren_free),
    .cq_free  (cq_free),
    .solo_fits(solo_fits),
    .pair_fits(pair_fits)
  );

  always_comb begin
    unit_clash = slot0_unit == slot1_unit;
    grant[0]   = unit_ready[0] && solo_fits;
    grant[1]   = grant[0] && unit_ready[1] && !unit_clash && pair_fits;
    disp_count = pair_pop(grant[0], grant[1]);
    ren_alloc  = pair_pop(grant[0] && slot0_wr, grant[1] && slot1_wr);
    cq_alloc   = disp_count;
  end

  always_comb begin
    AST_IN_ORDER: assert (!(grant[1] && !grant[0])) // R1
      else $error("younger entry dispatched alone");
    AST_COUNT_LIMIT: assert (disp_count <= 2'd2) // R1
      else $error("more than two dispatched");
    AST_REN_BOUND: assert (supply_covers(16'(ren_free), 16'(ren_alloc))) // R3
      else $error("rename allocation exceeds supply");
    AST_CQ_BOUND: assert (supply_covers(16'(cq_free), 16'(cq_alloc))) // R4
      else $error("completion allocation exceeds supply");
    AST_CLASH_HOLDS: assert (!(unit_clash && grant[1])) // R5
      else $error("same unit dispatched twice");
    AST_INVALID_IDLE: assert (slot1_valid || !grant[1]) // R7
      else $error("invalid younger entry dispatched");
    AST_ALLOC_MATCH: assert (ren_alloc <= cq_alloc) // R8
      else $error("rename request exceeds dispatched count");
  end

endmodule

// File: tb/dispatch_ctrl_test.sv
module dispatch_ctrl_test;
  localparam int NUM_UNITS = 8;
  localparam int UNIT_W    = 3;
  localparam int REN_W     = 6;
  localparam int CQ_W      = 4;
  localparam int NVEC      = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 v0, w0, v1, w1;
  logic [UNIT_W-1:0]    u0, u1;
  logic [NUM_UNITS-1:0] busy;
  logic [REN_W-1:0]     rf;
  logic [CQ_W-1:0]      cf;
  logic [1:0]           grant, disp_count, ren_alloc, cq_alloc;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  dispatch_ctrl uut (
    .slot0_valid(v0), .slot0_unit(u0), .slot0_wr(w0),
    .slot1_valid(v1), .slot1_unit(u1), .slot1_wr(w1),
    .unit_busy(busy), .ren_free(rf), .cq_free(cf),
    .grant(grant), .disp_count(disp_count),
    .ren_alloc(ren_alloc), .cq_alloc(cq_alloc)
  );

  // Row layout: v0,u0,w0, v1,u1,w1, busy, ren_free, cq_free, expected grant
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b1,3'd1,1'b0, 1'b1,3'd2,1'b0, 8'h00, 6'd4, 4'd8, 2'b11}, // R1 pair on free units
    {1'b1,3'd1,1'b0, 1'b1,3'd2,1'b0, 8'h02, 6'd4, 4'd8, 2'b00}, // R2 older unit busy
    {1'b1,3'd1,1'b0, 1'b1,3'd2,1'b0, 8'h04, 6'd4, 4'd8, 2'b01}, // R2 younger unit busy
    {1'b1,3'd3,1'b0, 1'b1,3'd3,1'b0, 8'h00, 6'd4, 4'd8, 2'b01}, // R5 shared unit
    {1'b1,3'd1,1'b0, 1'b1,3'd2,1'b0, 8'h00, 6'd4, 4'd0, 2'b00}, // R4 no cq entry
    {1'b1,3'd1,1'b0, 1'b1,3'd2,1'b0, 8'h00, 6'd4, 4'd1, 2'b01}, // R6 one cq entry
    {1'b1,3'd1,1'b1, 1'b1,3'd2,1'b0, 8'h00, 6'd0, 4'd8, 2'b00}, // R3 no rename
    {1'b1,3'd1,1'b1, 1'b1,3'd2,1'b1, 8'h00, 6'd1, 4'd8, 2'b01}, // R6 one rename for two
    {1'b1,3'd1,1'b0, 1'b1,3'd2,1'b1, 8'h00, 6'd1, 4'd8, 2'b11}, // R3 one rename suffices
    {1'b0,3'd1,1'b0, 1'b1,3'd2,1'b0, 8'h00, 6'd4, 4'd8, 2'b00}, // R7 invalid older
    {1'b1,3'd1,1'b0, 1'b0,3'd2,1'b1, 8'h00, 6'd1, 4'd8, 2'b01}, // R7 invalid younger
    {1'b1,3'd0,1'b1, 1'b1,3'd7,1'b1, 8'h7E, 6'd2, 4'd2, 2'b11}  // R8 exact supply, edge units
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [29:0] row);
    {v0,u0,w0,v1,u1,w1,busy,rf,cf} = row[29:2];
    @(negedge clk);
  endtask

  // Expected-value rules, written from the requirements.
  function automatic int exp_grants(input logic a0, input logic [2:0] a_u, input logic a_w,
                                    input logic b1, input logic [2:0] b_u, input logic b_w,
                                    input logic [7:0] bz, input int ren, input int cq);
    int g;
    int need;
    g = 0;
    if (a0 && !bz[a_u] && cq >= 1 && ren >= int'(a_w)) begin
      g = 1;
      need = int'(a_w) + int'(b_w);
      if (b1 && !bz[b_u] && a_u != b_u && cq >= 2 && ren >= need) g = 3;
    end
    return g;
  endfunction

  task automatic check_outputs(input string req, input int g);
    int n;
    int r;
    n = (g == 3) ? 2 : (g == 1 ? 1 : 0);
    r = ((g & 1) != 0 && w0 ? 1 : 0) + ((g & 2) != 0 && w1 ? 1 : 0);
    check(req, "grant", int'(grant), g);
    check("R1", "disp_count", int'(disp_count), n);
    check("R8", "ren_alloc", int'(ren_alloc), r);
    check("R8", "cq_alloc", int'(cq_alloc), n);
  endtask

  initial begin : watchdog
    while (cycles < 100000 && !done) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    // Idle queue: nothing dispatches (R7).
    apply({1'b0,3'd0,1'b0, 1'b0,3'd0,1'b0, 8'h00, 6'd8, 4'd8, 2'b00});
    check_outputs("R7", 0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i]);
      check_outputs($sformatf("R1/R2/R3/R4/R5/R6/R7 row %0d", i), int'(VEC[i][1:0]));
    end

    // Same-cycle response to a supply change (R9).
    apply({1'b1,3'd4,1'b0, 1'b1,3'd5,1'b0, 8'h00, 6'd0, 4'd2, 2'b11});
    check("R9", "grant after cq rise", int'(grant), 3);
    cf = 4'd1;
    #1;
    check("R9", "grant after cq drop", int'(grant), 1);
    @(negedge clk);

    // Sweep of threshold cases against the bench model (R6, R3, R5).
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 3; r++)
        for (int f = 0; f < 4; f++)
          for (int same = 0; same < 2; same++) begin
            v0 = 1'b1; v1 = 1'b1;
            u0 = 3'd6; u1 = same ? 3'd6 : 3'd1;
            w0 = f[0]; w1 = f[1];
            busy = 8'h00;
            rf = REN_W'(r); cf = CQ_W'(c);
            @(negedge clk);
            check_outputs("R6", exp_grants(v0,u0,w0,v1,u1,w1,busy,r,c));
          end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule